// File: doc/BRIEF.md
# Linked Transmit Descriptor Walker

The walker keeps track of the transmit descriptor currently in use inside a singly linked list held in host memory. While it is idle, software loads a 32-bit pointer register with the address of a descriptor that has already been completed. Software then pulses a transmit-enable command. The walker reads the link word of the current descriptor through a request/acknowledge read port. For a non-null link, it moves the pointer to the linked descriptor and fetches again. When the link word is null, it parks on the current descriptor and goes idle.

Parking on the tail, rather than clearing the pointer, lets software append descriptors to the end of the list and issue another enable command. That command makes the walker re-read the tail's link word and continue into the new entries. An enable command that arrives while a walk is still running is remembered. If the walk then meets a null link, the current descriptor is fetched once more, so a late append is never missed. The pointer value is always visible to software and drives the fetch address.

Top module: `tx_desc_walker`

## Requirements
- R1: After the asynchronous reset `ptr_o` is 0, `busy_o` is 0 and `mem_req_o` is 0.
- R2: A pointer write while idle loads `ptr_wdata_i` with bits 1:0 forced to 0, visible on `ptr_o` one cycle later; `ptr_o[1:0]` is always 0.
- R3: A pointer write while `busy_o` is 1 is ignored; the walk and the pointer value are unaffected.
- R4: `txe_i` while idle sets `busy_o` and `mem_req_o` the next cycle, with `mem_addr_o` equal to `ptr_o + LINK_OFS` (LINK_OFS defaults to 0).
- R5: Once raised, `mem_req_o` stays 1 and `mem_addr_o` stays constant until a cycle with `mem_ack_i` high.
- R6: An acknowledged link word that is not all zeros is loaded into the pointer with bits 1:0 cleared, one cycle after the acknowledge, and the walker keeps fetching from the new descriptor.
- R7: An acknowledged all-zero link word leaves the pointer unchanged and, unless R8 applies, clears `busy_o` and `mem_req_o` one cycle later.
- R8: A `txe_i` pulse seen while busy is held. When the next null link is acknowledged, the walker re-fetches the same descriptor's link word instead of going idle, and the held request is then consumed.
- R9: `txe_i` after parking on the tail re-reads the tail's link word, so descriptors appended after the walk ended are followed.
- R10: `soft_rst_i` high for one cycle clears the pointer to 0, drops `busy_o` and `mem_req_o`, and discards a held enable request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Synchronous soft reset |
| ptr_we_i | input | 1 | Software write strobe for the pointer register |
| ptr_wdata_i | input | ADDR_W | Pointer write data |
| txe_i | input | 1 | Transmit-enable command pulse |
| ptr_o | output | ADDR_W | Current descriptor address (software read value) |
| busy_o | output | 1 | Walker active |
| mem_req_o | output | 1 | Link-word read request |
| mem_addr_o | output | ADDR_W | Read address of the link word |
| mem_ack_i | input | 1 | Read data valid |
| mem_rdata_i | input | ADDR_W | Returned link word |

## Verification
If the walker's state is wrong, the sequence of addresses it requests differs from the chain laid out in memory. This shows up at the first acknowledge after the fault. A missed rearm or a spurious rearm shows up as a tail fetch that is missing or duplicated. A pointer that should have stayed put shows up at `ptr_o` one cycle after the offending acknowledge or write. The bench sweeps list length, descriptor stride, low link bits and memory latency. It compares the recorded fetch sequence and the parked pointer against chains it computes itself.

// File: rtl/tdw_pkg.sv
package tdw_pkg;
  localparam int unsigned ALIGN_W = 2;

  typedef enum logic {
    WK_IDLE  = 1'b0,
    WK_FETCH = 1'b1
  } walk_state_e;
endpackage

// File: rtl/tdw_link_chk.sv
module tdw_link_chk
  import tdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] link_i,
  output logic              null_o,
  output logic [ADDR_W-1:0] next_o
);
  assign null_o = (link_i == '0);
  assign next_o = {link_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
endmodule

// File: rtl/tdw_ptr_reg.sv
module tdw_ptr_reg
  import tdw_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sw_we_i,
  input  logic [ADDR_W-1:0] sw_data_i,
  input  logic              hw_we_i,
  input  logic [ADDR_W-1:0] hw_data_i,
  output logic [ADDR_W-1:0] ptr_o
);
  logic [ADDR_W-1:0] ptr_q;

  // clear > walker advance > software load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (hw_we_i) ptr_q <= hw_data_i;
    else if (sw_we_i) ptr_q <= {sw_data_i[ADDR_W-1:ALIGN_W], {ALIGN_W{1'b0}}};
  end

  assign ptr_o = ptr_q;

  assert_aligned_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q[ALIGN_W-1:0] == '0);
endmodule

// File: rtl/tdw_fsm.sv
module tdw_fsm
  import tdw_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic txe_i,
  input  logic ack_i,
  input  logic link_null_i,
  output logic busy_o,
  output logic req_o,
  output logic adv_o
);
  walk_state_e state_q, state_d;
  logic        rearm_q, rearm_d;
  logic        end_hit;

  assign end_hit = (state_q == WK_FETCH) && ack_i && link_null_i;

  always_comb begin
    state_d = state_q;
    rearm_d = rearm_q;
    unique case (state_q)
      WK_IDLE: if (txe_i) state_d = WK_FETCH;
      WK_FETCH: begin
        if (end_hit) begin
          rearm_d = 1'b0;
          if (!(rearm_q || txe_i)) state_d = WK_IDLE;
        end else if (txe_i) begin
          rearm_d = 1'b1;
        end
      end
      default: state_d = WK_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= WK_IDLE;
      rearm_q <= 1'b0;
    end else if (clr_i) begin
      state_q <= WK_IDLE;
      rearm_q <= 1'b0;
    end else begin
      state_q <= state_d;
      rearm_q <= rearm_d;
    end
  end

  assign busy_o = (state_q == WK_FETCH);
  assign req_o  = busy_o;
  assign adv_o  = busy_o && ack_i && !link_null_i;

  assert_rearm_refetch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (end_hit && rearm_q && !clr_i) |=> (busy_o && !rearm_q));
  assert_idle_rearm_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rearm_q);
endmodule

// File: rtl/tx_desc_walker.sv
module tx_desc_walker
  import tdw_pkg::*;
#(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned LINK_OFS = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              soft_rst_i,
  input  logic              ptr_we_i,
  input  logic [ADDR_W-1:0] ptr_wdata_i,
  input  logic              txe_i,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              busy_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_ack_i,
  input  logic [ADDR_W-1:0] mem_rdata_i
);
  localparam logic [ADDR_W-1:0] LinkOfs = ADDR_W'(LINK_OFS);

  logic              link_null;
  logic [ADDR_W-1:0] link_next;
  logic              adv;
  logic              busy;

  tdw_link_chk #(.ADDR_W(ADDR_W)) u_link (
    .link_i (mem_rdata_i),
    .null_o (link_null),
    .next_o (link_next)
  );

  tdw_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (soft_rst_i),
    .txe_i       (txe_i),
    .ack_i       (mem_ack_i),
    .link_null_i (link_null),
    .busy_o      (busy),
    .req_o       (mem_req_o),
    .adv_o       (adv)
  );

  // software load accepted only while idle
  tdw_ptr_reg #(.ADDR_W(ADDR_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (soft_rst_i),
    .sw_we_i   (ptr_we_i && !busy),
    .sw_data_i (ptr_wdata_i),
    .hw_we_i   (adv),
    .hw_data_i (link_next),
    .ptr_o     (ptr_o)
  );

  assign busy_o     = busy;
  assign mem_addr_o = ptr_o + LinkOfs;

  assert_req_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i && !soft_rst_i) |=> (mem_req_o && $stable(mem_addr_o)));
  assert_busy_write_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ptr_we_i && !mem_ack_i && !soft_rst_i) |=> $stable(ptr_o));
  assert_advance_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && (mem_rdata_i != '0) && !soft_rst_i)
      |=> (ptr_o == {$past(mem_rdata_i[ADDR_W-1:ALIGN_W]), {ALIGN_W{1'b0}}}) && busy_o);
  assert_null_park_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i && (mem_rdata_i == '0) && !soft_rst_i) |=> $stable(ptr_o));
  assert_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && txe_i && !soft_rst_i) |=> (busy_o && mem_req_o));
  assert_soft_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (ptr_o == '0 && !busy_o && !mem_req_o));
endmodule

// File: tb/tb_tx_desc_walker.sv
module tb_tx_desc_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic        ptr_we = 1'b0;
  logic [31:0] ptr_wdata = '0;
  logic        txe = 1'b0;
  logic [31:0] ptr;
  logic        busy, mem_req, mem_ack;
  logic [31:0] mem_addr, mem_rdata;

  always #5 clk = ~clk;

  tx_desc_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst),
    .ptr_we_i(ptr_we), .ptr_wdata_i(ptr_wdata), .txe_i(txe),
    .ptr_o(ptr), .busy_o(busy),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int          checks = 0, errors = 0;
  bit          done = 1'b0;
  logic [31:0] mem [0:63];
  logic [31:0] visited [0:31];
  int          nvis = 0;
  int          lat = 1;
  int          cnt = 0;
  int          hold_viol = 0;
  logic [31:0] last_addr = '0;
  bit          pending = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // fixed-latency memory model, acts at negedge
  initial begin
    mem_ack = 1'b0;
    mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (!mem_req || mem_ack) begin
        mem_ack = 1'b0;
        cnt = 0;
        pending = 1'b0;
      end else begin
        if (pending && mem_addr != last_addr) hold_viol++;
        pending = 1'b1;
        last_addr = mem_addr;
        cnt++;
        if (cnt >= lat) begin
          mem_ack = 1'b1;
          mem_rdata = mem[mem_addr[7:2]];
          if (nvis < 32) visited[nvis] = mem_addr;
          nvis++;
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
    summary();
  end

  function automatic logic [31:0] daddr(input int base, input int stride, input int k);
    return 32'(base + k * stride);
  endfunction

  task automatic build(input int base, input int stride, input int len);
    for (int i = 0; i < 64; i++) mem[i] = '0;
    for (int k = 0; k < len; k++)
      mem[daddr(base, stride, k) >> 2] = (k == len - 1) ? 32'd0 : (daddr(base, stride, k + 1) | 32'(k % 4));
  endtask

  task automatic load_ptr(input logic [31:0] v);
    @(negedge clk);
    ptr_we = 1'b1;
    ptr_wdata = v;
    @(negedge clk);
    ptr_we = 1'b0;
  endtask

  task automatic start_txe();
    @(negedge clk);
    txe = 1'b1;
    @(negedge clk);
    txe = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
  endtask

  task automatic check_walk(input int base, input int stride, input int len, input bit extra_tail,
                            input string req);
    int  exp_n;
    bit  seq_ok;
    exp_n = len + (extra_tail ? 1 : 0);
    chk(nvis == exp_n, req, 32'(nvis), 32'(exp_n));
    seq_ok = 1'b1;
    for (int k = 0; k < exp_n && k < 32; k++)
      if (visited[k] != daddr(base, stride, (k < len) ? k : len - 1)) seq_ok = 1'b0;
    chk(seq_ok, req, visited[0], daddr(base, stride, 0));
    chk(ptr == daddr(base, stride, len - 1), "R7", ptr, daddr(base, stride, len - 1));
    chk(!busy && !mem_req, "R7", {30'd0, busy, mem_req}, 32'd0);
  endtask

  initial begin
    int strides [3] = '{8, 12, 20};
    int lats [3] = '{1, 2, 4};
    int base;
    base = 16;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(ptr == 0 && !busy && !mem_req, "R1", ptr, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ptr == 0 && !busy && !mem_req, "R1", ptr, 32'd0);

    // sweep: R2 R3 R4 R6 R7
    for (int si = 0; si < 3; si++) begin
      for (int li = 0; li < 3; li++) begin
        for (int len = 1; len <= 6; len++) begin
          lat = lats[li];
          build(base, strides[si], len);
          load_ptr(32'(base) | 32'(len % 4));
          chk(ptr == 32'(base), "R2", ptr, 32'(base));
          nvis = 0;
          start_txe();
          chk(busy && mem_req && mem_addr == 32'(base), "R4", mem_addr, 32'(base));
          if (li == 1) begin
            // R3: write while busy must not disturb the walk
            ptr_we = 1'b1;
            ptr_wdata = 32'h0000_00F0;
            @(negedge clk);
            ptr_we = 1'b0;
          end
          wait_idle();
          check_walk(base, strides[si], len, 1'b0, (li == 1) ? "R3" : "R6");
        end
      end
    end
    chk(hold_viol == 0, "R5", 32'(hold_viol), 32'd0);

    // R8: enable while busy forces one extra fetch of the tail
    for (int len = 1; len <= 4; len++) begin
      lat = 3;
      build(base, 12, len);
      load_ptr(32'(base));
      nvis = 0;
      start_txe();
      start_txe();
      wait_idle();
      check_walk(base, 12, len, 1'b1, "R8");
    end

    // R9: append after parking, then re-enable
    for (int len = 1; len <= 3; len++) begin
      lat = 2;
      build(base, 8, len);
      load_ptr(32'(base));
      nvis = 0;
      start_txe();
      wait_idle();
      mem[daddr(base, 8, len - 1) >> 2] = 32'h0000_00F1;
      mem[32'hF0 >> 2] = 32'd0;
      nvis = 0;
      start_txe();
      wait_idle();
      chk(nvis == 2 && visited[0] == daddr(base, 8, len - 1) && visited[1] == 32'hF0,
          "R9", visited[1], 32'hF0);
      chk(ptr == 32'hF0 && !busy, "R9", ptr, 32'hF0);
    end

    // R10: soft reset mid-walk
    lat = 4;
    build(base, 8, 5);
    load_ptr(32'(base));
    start_txe();
    repeat (3) @(negedge clk);
    soft_rst = 1'b1;
    @(negedge clk);
    soft_rst = 1'b0;
    chk(ptr == 0 && !busy && !mem_req, "R10", ptr, 32'd0);
    repeat (8) @(negedge clk);
    chk(!busy && !mem_req && ptr == 0, "R10", {30'd0, busy, mem_req}, 32'd0);

    summary();
  end
endmodule